// File: doc/BRIEF.md
# Three-Level Error PID Loop Filter

This block is the compensator of a digital voltage-mode multiphase regulator. Once per switching period a strobe delivers a coarse error code from two window comparators. The code says whether the output voltage lies below the reference window, inside it, or above it. The block turns that sign into a duty-cycle word of N+M bits: N coarse bits for the PWM counter and M bits for a dither stage that follows it. A single duty word feeds every phase, so no per-phase current sensing is needed.

The command is the sum of three terms. The proportional term follows the error sign. The derivative term follows the change of the sign. The third is an integrator that is stepped only once every 2^k samples, with a resolution of half a duty LSB. The integrator is kept slow on purpose. The fast terms pull the output toward the reference window, and the integrator then walks the duty word to a level that sits inside the zero-error window. The output therefore does not limit-cycle between quantization bins. The duty word is clamped to its code range. The integrator freezes whenever stepping it would push further into a clamp.

A 5-bit voltage-select input chooses the regulation target. The block does not apply a new target at once. It moves an internal reference code one step at a time toward the selected value, one step per sixteen samples. That code drives the slow reference DAC.

Top module: `bin_pid_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `duty` becomes 0, the integrator and both sample counters clear, and `ref_level` loads the current `vid` value.
- R2: The error code is decoded as follows: 2'b10 (output below the window) means +1, 2'b01 (output above the window) means -1, and both 2'b00 (inside the window) and 2'b11 (invalid) mean 0.
- R3: The proportional term is e*KP. The derivative term is (e - e_prev)*KD when e is nonzero, where e_prev is the error of the previous sample. For an error of 0, both terms are zero and `duty` equals the integrator value divided by two.
- R4: A sample counter starts at 0 and advances on every sample. The integrator is stepped only on a sample where the low `int_shift` bits of the counter are all ones, so once every 2^int_shift samples. A step adds e in units of half a duty LSB, and the integrator stays within 0 to 2^(N+M+1)-1.
- R5: On each `sample_valid` pulse, `duty` takes the value floor(acc/2) + P + D in the next cycle, where acc is the integrator value after that sample's step. Without a pulse, `duty` keeps its value.
- R6: The duty sum is clamped: below 0 it gives 0, above 2^(N+M)-1 it gives 2^(N+M)-1.
- R7: The integrator does not step on a sample with e = -1 while `duty` is 0, or with e = +1 while `duty` is at full scale.
- R8: A reference counter runs while `ref_level` differs from `vid`. On the sixteenth such sample, `ref_level` moves one code toward `vid` and the counter restarts. When `ref_level` equals `vid`, the counter is held at 0. Without a sample, `ref_level` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe, one per switching period |
| err_code | input | 2 | Window comparator code (encoding in R2) |
| vid | input | 5 | Target voltage-select code |
| int_shift | input | 3 | Integrator slow-down exponent k |
| duty | output | 10 | Registered duty command, N+M bits |
| ref_level | output | 5 | Registered stepped reference code |

## Verification
The bench uses the default parameters: N=7 and M=3, which give a 10-bit duty word, KP=8, KD=4, a 3-bit slow-down exponent and a reference divide of 16. It runs phases with `int_shift` at 4, which exercises the slow integrator cadence of R4. It also runs phases with `int_shift` at 0, where the integrator steps on every sample. At that setting the 2047-step integrator can reach the top clamp in a few thousand samples, which brings R6 and R7 at full scale within reach. Voltage-select changes in both directions let the sixteen-sample stepping of R8 complete several codes.

// File: rtl/bin_pid_pkg.sv
package bin_pid_pkg;

  // Signed error sign taken from the window comparators
  typedef logic signed [1:0] err_t;

  localparam err_t ERR_NEG  = -2'sd1;
  localparam err_t ERR_ZERO = 2'sd0;
  localparam err_t ERR_POS  = 2'sd1;

  // Comparator code values
  typedef enum logic [1:0] {
    CODE_INSIDE = 2'b00,
    CODE_ABOVE  = 2'b01,
    CODE_BELOW  = 2'b10,
    CODE_BAD    = 2'b11
  } win_code_e;

endpackage

// File: rtl/bin_pid_err_decode.sv
module bin_pid_err_decode
  import bin_pid_pkg::*;
(
  input  logic [1:0] code_i,
  output err_t       err_o
);

  // R2: below the window raises duty, above lowers it, anything else is zero
  always_comb begin
    unique case (code_i)
      CODE_BELOW: err_o = ERR_POS;
      CODE_ABOVE: err_o = ERR_NEG;
      default:    err_o = ERR_ZERO;
    endcase
  end

endmodule

// File: rtl/bin_pid_integrator.sv
module bin_pid_integrator
  import bin_pid_pkg::*;
#(
  parameter int ACC_W = 11,
  parameter int SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_valid,
  input  err_t             err_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             hold_i,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] acc_nxt
);

  localparam int CNT_W = (1 << SH_W) - 1;
  localparam logic [ACC_W-1:0] ACC_TOP = {ACC_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             step_en;

  always_comb begin
    mask    = ~({CNT_W{1'b1}} << shift_i);
    step_en = sample_valid && ((cnt_q & mask) == mask);
  end

  // Half-LSB step, clamped at both ends, frozen under anti-windup
  always_comb begin
    acc_nxt = acc_q;
    if (step_en && !hold_i) begin
      if (err_i == ERR_POS && acc_q != ACC_TOP)
        acc_nxt = acc_q + 1'b1;
      else if (err_i == ERR_NEG && acc_q != '0)
        acc_nxt = acc_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (sample_valid) begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= acc_nxt;
    end
  end

  // R4
  int_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(acc_q));

  // R4
  int_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (acc_q == $past(acc_q) || acc_q == $past(acc_q) + 1'b1 ||
                 acc_q == $past(acc_q) - 1'b1));

endmodule

// File: rtl/bin_pid_ref_stepper.sv
module bin_pid_ref_stepper #(
  parameter int VID_W   = 5,
  parameter int REF_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_valid,
  input  logic [VID_W-1:0] vid_i,
  output logic [VID_W-1:0] ref_q
);

  localparam int DIV_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= vid_i;
      div_q <= '0;
    end else if (sample_valid) begin
      if (ref_q == vid_i) begin
        div_q <= '0;
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (ref_q < vid_i) ref_q <= ref_q + 1'b1;
        else               ref_q <= ref_q - 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R8
  ref_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(ref_q));

  // R8
  ref_up_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && ref_q < vid_i) |=>
      (ref_q == $past(ref_q) || ref_q == $past(ref_q) + 1'b1));

  // R8
  ref_down_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && ref_q > vid_i) |=>
      (ref_q == $past(ref_q) || ref_q == $past(ref_q) - 1'b1));

endmodule

// File: rtl/bin_pid_ctrl.sv
module bin_pid_ctrl
  import bin_pid_pkg::*;
#(
  parameter int N_BITS  = 7,
  parameter int M_BITS  = 3,
  parameter int KP      = 8,
  parameter int KD      = 4,
  parameter int SH_W    = 3,
  parameter int VID_W   = 5,
  parameter int REF_DIV = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_valid,
  input  logic [1:0]               err_code,
  input  logic [VID_W-1:0]         vid,
  input  logic [SH_W-1:0]          int_shift,
  output logic [N_BITS+M_BITS-1:0] duty,
  output logic [VID_W-1:0]         ref_level
);

  localparam int DW    = N_BITS + M_BITS;
  localparam int ACC_W = DW + 1;
  localparam int SW    = DW + 4;
  localparam logic [DW-1:0]        DUTY_TOP = {DW{1'b1}};
  localparam logic signed [SW-1:0] FULL_S   = SW'((1 << DW) - 1);
  localparam logic signed [SW-1:0] KP_S     = SW'(KP);
  localparam logic signed [SW-1:0] KD_S     = SW'(KD);

  err_t                    err;
  err_t                    err_prev_q;
  logic                    hold;
  logic [ACC_W-1:0]        acc_q;
  logic [ACC_W-1:0]        acc_nxt;
  logic signed [2:0]       err_diff;
  logic signed [SW-1:0]    p_term;
  logic signed [SW-1:0]    d_term;
  logic signed [SW-1:0]    base;
  logic signed [SW-1:0]    sum;
  logic [DW-1:0]           duty_sat;
  logic [DW-1:0]           duty_q;

  bin_pid_err_decode dec_i (
    .code_i (err_code),
    .err_o  (err)
  );

  // R7: freeze the integrator when stepping would push into a clamp
  always_comb begin
    hold = (duty_q == '0 && err == ERR_NEG) ||
           (duty_q == DUTY_TOP && err == ERR_POS);
  end

  bin_pid_integrator #(
    .ACC_W (ACC_W),
    .SH_W  (SH_W)
  ) integ_i (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .err_i        (err),
    .shift_i      (int_shift),
    .hold_i       (hold),
    .acc_q        (acc_q),
    .acc_nxt      (acc_nxt)
  );

  bin_pid_ref_stepper #(
    .VID_W   (VID_W),
    .REF_DIV (REF_DIV)
  ) ref_i (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .vid_i        (vid),
    .ref_q        (ref_level)
  );

  // Proportional and derivative terms, both zero for a zero error
  always_comb begin
    err_diff = 3'(err) - 3'(err_prev_q);
    p_term   = SW'(err) * KP_S;
    d_term   = (err == ERR_ZERO) ? '0 : SW'(err_diff) * KD_S;
    base     = $signed({{(SW-ACC_W){1'b0}}, acc_nxt}) >>> 1;
    sum      = base + p_term + d_term;
  end

  // R6: clamp to the duty code range
  always_comb begin
    if (sum < 0)
      duty_sat = '0;
    else if (sum > FULL_S)
      duty_sat = DUTY_TOP;
    else
      duty_sat = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q     <= '0;
      err_prev_q <= ERR_ZERO;
    end else if (sample_valid) begin
      duty_q     <= duty_sat;
      err_prev_q <= err;
    end
  end

  assign duty = duty_q;

  // R5
  duty_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(duty_q));

  // R3
  zero_err_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && err == ERR_ZERO) |=> ACC_W'(duty_q) == $past(acc_q >> 1));

  // R7
  windup_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && duty_q == '0 && err == ERR_NEG) |=> $stable(acc_q));

  // R7
  windup_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && duty_q == DUTY_TOP && err == ERR_POS) |=> $stable(acc_q));

endmodule

// File: tb/bin_pid_ctrl_tb_top.sv
module bin_pid_ctrl_tb_top;

  localparam int DUTY_MAX = 1023;
  localparam int ACC_MAX  = 2047;
  localparam int KP       = 8;
  localparam int KD       = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       sample_valid;
  logic [1:0] err_code;
  logic [4:0] vid;
  logic [2:0] int_shift;
  logic [9:0] duty;
  logic [4:0] ref_level;

  always #5 clk = ~clk;

  bin_pid_ctrl dut_i (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .err_code     (err_code),
    .vid          (vid),
    .int_shift    (int_shift),
    .duty         (duty),
    .ref_level    (ref_level)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model state
  int m_acc, m_eprev, m_cnt, m_duty, m_ref, m_refcnt;

  int    q_duty[$];
  int    q_ref[$];
  string q_tag[$];

  task automatic check(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: update model, push expectation, pulse the strobe
  task automatic do_sample(input logic [1:0] code, input string tag);
    int e, mask, acc_n, s;
    bit hold;
    @(negedge clk);
    e    = (code == 2'b10) ? 1 : (code == 2'b01) ? -1 : 0;
    mask = (1 << int_shift) - 1;
    hold = (m_duty == 0 && e < 0) || (m_duty == DUTY_MAX && e > 0);
    acc_n = m_acc;
    if (((m_cnt & mask) == mask) && !hold) begin
      if (e > 0 && acc_n < ACC_MAX) acc_n++;
      else if (e < 0 && acc_n > 0) acc_n--;
    end
    s = (acc_n >> 1) + e * KP + ((e != 0) ? (e - m_eprev) * KD : 0);
    if (s < 0) s = 0;
    if (s > DUTY_MAX) s = DUTY_MAX;
    m_cnt   = (m_cnt + 1) % 128;
    m_eprev = e;
    m_acc   = acc_n;
    m_duty  = s;
    if (m_ref != int'(vid)) begin
      if (m_refcnt == 15) begin
        m_refcnt = 0;
        m_ref = (m_ref < int'(vid)) ? m_ref + 1 : m_ref - 1;
      end else m_refcnt++;
    end else m_refcnt = 0;
    q_duty.push_back(m_duty);
    q_ref.push_back(m_ref);
    q_tag.push_back(tag);
    err_code     = code;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  // monitor: a strobe taken at an edge is compared at the following negedge
  bit pend = 1'b0;
  always @(posedge clk) pend <= sample_valid && !rst;

  always @(negedge clk) begin
    if (pend) begin
      if (q_duty.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R5: actual output update, expected none queued");
      end else begin
        string t;
        int ed, er;
        ed = q_duty.pop_front();
        er = q_ref.pop_front();
        t  = q_tag.pop_front();
        check(int'(duty), ed, {t, " duty"});
        check(int'(ref_level), er, "R8 ref_level");
      end
    end
  end

  task automatic idle_check(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(int'(duty), m_duty, "R5 idle duty");
      check(int'(ref_level), m_ref, "R8 idle ref_level");
    end
  endtask

  initial begin
    rst = 1'b1; sample_valid = 1'b0; err_code = 2'b00;
    vid = 5'd10; int_shift = 3'd4;
    m_acc = 0; m_eprev = 0; m_cnt = 0; m_duty = 0; m_ref = 10; m_refcnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    check(int'(duty), 0, "R1 reset duty");
    check(int'(ref_level), 10, "R1 reset ref_level");

    // R2 / R3: zero codes keep duty at integrator/2 = 0
    do_sample(2'b00, "R2 inside");
    do_sample(2'b11, "R2 invalid");
    // R4: slow cadence at k=4, steady +1 then a mix
    for (int i = 0; i < 40; i++) do_sample(2'b10, "R4 slow up");
    for (int i = 0; i < 20; i++) do_sample((i % 3 == 0) ? 2'b01 : 2'b10, "R3 mixed");
    do_sample(2'b00, "R3 zero after error");
    idle_check(5);

    // R3: sign reversals at every-sample integration
    int_shift = 3'd0;
    for (int i = 0; i < 12; i++) do_sample((i % 2) ? 2'b01 : 2'b10, "R3 alternate");
    // R6 / R7: drive to the bottom clamp with -1 and hold
    for (int i = 0; i < 30; i++) do_sample(2'b01, "R7 low clamp");
    do_sample(2'b00, "R6 low zero");
    // R6 / R7: ramp to full scale and keep pushing
    for (int i = 0; i < 2100; i++) do_sample(2'b10, "R6 ramp up");
    for (int i = 0; i < 20; i++) do_sample(2'b10, "R7 high clamp");
    do_sample(2'b11, "R2 invalid at top");
    for (int i = 0; i < 40; i++) do_sample(2'b01, "R6 leave top");

    // R8: reference stepping up and down
    vid = 5'd13;
    int_shift = 3'd4;
    for (int i = 0; i < 60; i++) do_sample(2'b00, "R8 step up");
    idle_check(3);
    vid = 5'd4;
    for (int i = 0; i < 200; i++) do_sample((i % 4 == 0) ? 2'b10 : 2'b00, "R8 step down");

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1; vid = 5'd21;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_acc = 0; m_eprev = 0; m_cnt = 0; m_duty = 0; m_ref = 21; m_refcnt = 0;
    check(int'(duty), 0, "R1 second reset duty");
    check(int'(ref_level), 21, "R1 second reset ref_level");
    for (int i = 0; i < 20; i++) do_sample(2'b10, "R4 after reset");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule